// File: doc/BRIEF.md
# Bus-Mapped Command Latch and Fault Reader

This block is a slave on a host processor's asynchronous parallel bus. It gives the host four latched command outputs and lets it poll four fault lines. The host reaches eight channel slots through an active-low chip select, a 3-bit address, active-low read and write strobes and a 6-bit bidirectional data bus. Slots 0 to 3 are command registers that the host writes. Slots 4 to 7 report the current level of fault inputs 0 to 3 when the host reads them. A fault line goes high when its fault appears and stays high until the fault clears. The host learns of faults only by polling, because the block raises no interrupt.

Everything runs on one system clock. The bus strobes, address and write data pass through a synchronizer, and a write is committed on the rising edge of the synchronized write strobe. Each fault line has its own two-flop synchronizer ahead of the read multiplexer. The block drives the data bus only while both the chip select and the read strobe are low and reset is not active. At all other times the bus floats, so the block never contends with other devices sharing the bus, such as a boot memory during start-up.

Top module: `bus_cmd_fault_slave`

## Requirements
- R1: While reset is high and after it is released, every command output is 0 until the host writes that channel.
- R2: A write with cs_n low to address k in 0..3 loads all 6 data bits into command channel k, which appears on cmd_out bits [6k+5:6k]. The other three channels keep their values.
- R3: A command channel keeps its value across writes to other channels and across reads, until the host writes that same channel again.
- R4: Writes to addresses 4..7 change no command output. Write strobes given while cs_n is high change no command output.
- R5: A read with cs_n low from address 4+k drives fault_in[k] on data bit 0 and 0 on data bits 5..1.
- R6: A read from addresses 0..3 drives 0 on all six data bits.
- R7: The block drives the data bus only while cs_n and rd_n are both low and rst is low. Otherwise the bus is high-impedance.
- R8: A command output changes exactly 3 clock edges after the edge at which wr_n is first sampled high. A change on a fault line shows on the bus 3 edges after it is first sampled. A read address shows on the bus 1 edge after it is sampled.
- R9: Holding wr_n low for a long time does not commit the write. The write commits once, when the strobe is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a write commits on its rising edge |
| addr | input | 3 | Channel slot address |
| bus_data | inout | 6 | Bidirectional data bus |
| fault_in | input | 4 | Fault levels, high means faulted |
| cmd_out | output | 24 | Four 6-bit command channels packed, channel k at [6k+5:6k] |

## Verification
A committed write appears on cmd_out at the third rising clock edge after wr_n is first sampled high. The bench therefore checks at the falling edge after the second rising edge that the old value is still present, and at the falling edge after the third that the new value has appeared. A fault change on an address that is held in a read shows on the bus three edges after the fault is first sampled, and an address change shows one edge after it is sampled. Every read sample is taken at a falling edge placed to match these counts. Bus release shows up as the bench's pull-up value, which the block can never drive during a read.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  localparam int unsigned DEF_DATA_W = 6;
  localparam int unsigned DEF_ADDR_W = 3;
  localparam int unsigned DEF_SYNC   = 2;

  // The address MSB splits the slot space into two halves.
  typedef enum logic {
    KIND_CMD = 1'b0,
    KIND_FLT = 1'b1
  } port_kind_e;
endpackage

// File: rtl/bcf_sync.sv
module bcf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bcf_cmd_bank.sv
module bcf_cmd_bank #(
  parameter int unsigned DATA_W  = 6,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_CMD = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         data,
  output logic [NUM_CMD*DATA_W-1:0] cmd_out
);
  logic [NUM_CMD-1:0] sel;

  // One-hot slot decode; slots at and above NUM_CMD match nothing.
  always_comb begin
    for (int k = 0; k < NUM_CMD; k++) begin
      sel[k] = commit && (addr == ADDR_W'(k));
    end
  end

  for (genvar ch = 0; ch < NUM_CMD; ch++) begin : g_chan
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (sel[ch]) q <= data;
    end
    assign cmd_out[ch*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/bcf_read_mux.sv
module bcf_read_mux
  import bcf_pkg::*;
#(
  parameter int unsigned DATA_W  = 6,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_FLT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_FLT-1:0] fault_s,
  output logic [DATA_W-1:0]  rd_q
);
  port_kind_e        kind;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    kind = port_kind_e'(addr[ADDR_W-1]);
    rd_d = '0;
    if (kind == KIND_FLT) rd_d[0] = fault_s[addr[ADDR_W-2:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end
endmodule

// File: rtl/bus_cmd_fault_slave.sv
module bus_cmd_fault_slave
  import bcf_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  localparam int unsigned NUM_SEL    = 1 << ADDR_W,
  localparam int unsigned NUM_CMD    = NUM_SEL / 2,
  localparam int unsigned NUM_FLT    = NUM_SEL - NUM_CMD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [ADDR_W-1:0]         addr,
  inout  wire  [DATA_W-1:0]         bus_data,
  input  logic [NUM_FLT-1:0]        fault_in,
  output logic [NUM_CMD*DATA_W-1:0] cmd_out
);
  localparam int unsigned BUS_W = 2 + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {2'b11, {(ADDR_W+DATA_W){1'b0}}};

  logic [BUS_W-1:0]   bus_s, bus_p;
  logic               cs_p, wr_s, wr_p;
  logic [ADDR_W-1:0]  addr_p;
  logic [DATA_W-1:0]  data_p;
  logic               commit;
  logic [NUM_FLT-1:0] fault_s;
  logic [DATA_W-1:0]  rd_q;
  logic               drive_en;

  // Strobes, address and write data share one synchronizer chain.
  bcf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, wr_n, addr, bus_data}),
    .q   (bus_s)
  );

  // One more stage: previous strobe level plus fields aligned to it.
  always_ff @(posedge clk) begin
    if (rst) bus_p <= BUS_IDLE;
    else     bus_p <= bus_s;
  end

  assign wr_s   = bus_s[BUS_W-2];
  assign cs_p   = bus_p[BUS_W-1];
  assign wr_p   = bus_p[BUS_W-2];
  assign addr_p = bus_p[DATA_W +: ADDR_W];
  assign data_p = bus_p[DATA_W-1:0];
  assign commit = wr_s && !wr_p && !cs_p;

  bcf_cmd_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CMD(NUM_CMD)) i_cmd_bank (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .addr    (addr_p),
    .data    (data_p),
    .cmd_out (cmd_out)
  );

  bcf_sync #(.W(NUM_FLT), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_flt_sync (
    .clk (clk),
    .rst (rst),
    .d   (fault_in),
    .q   (fault_s)
  );

  bcf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FLT(NUM_FLT)) i_read_mux (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .fault_s (fault_s),
    .rd_q    (rd_q)
  );

  // Enable decoded straight from the pins so the bus releases at once.
  assign drive_en = !rst && !cs_n && !rd_n;
  assign bus_data = drive_en ? rd_q : {DATA_W{1'bz}};
endmodule

// File: rtl/bus_cmd_fault_slave_chk.sv
module bus_cmd_fault_slave_chk #(
  parameter int unsigned DATA_W = 6,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NUM_SEL = 1 << ADDR_W,
  localparam int unsigned NUM_CMD = NUM_SEL / 2,
  localparam int unsigned NUM_FLT = NUM_SEL - NUM_CMD
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cs_n,
  input logic                      rd_n,
  input logic                      wr_n,
  input logic [ADDR_W-1:0]         addr,
  input wire  [DATA_W-1:0]         bus_data,
  input logic [NUM_FLT-1:0]        fault_in,
  input logic [NUM_CMD*DATA_W-1:0] cmd_out
);
  logic [2:0]         age;
  logic [NUM_FLT-1:0] f_d1, f_d2, f_d3;
  logic [ADDR_W-1:0]  addr_d1;
  logic               reading;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 7)  age <= age + 3'd1;
    f_d1    <= fault_in;
    f_d2    <= f_d1;
    f_d3    <= f_d2;
    addr_d1 <= addr;
  end

  assign reading = !cs_n && !rd_n && (age >= 3'd5);

  assert_cmd_reset_R1: assert property (@(posedge clk)
    rst |=> (cmd_out == '0));

  assert_cmd_edge_timing_R8: assert property (@(posedge clk) disable iff (rst)
    ((age >= 3'd5) && !$stable(cmd_out)) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));

  assert_fault_read_R5: assert property (@(posedge clk) disable iff (rst)
    (reading && addr_d1[ADDR_W-1]) |->
      (bus_data == {{(DATA_W-1){1'b0}}, f_d3[addr_d1[ADDR_W-2:0]]}));

  assert_cmd_slot_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reading && !addr_d1[ADDR_W-1]) |-> (bus_data == '0));
endmodule

bind bus_cmd_fault_slave bus_cmd_fault_slave_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .addr     (addr),
  .bus_data (bus_data),
  .fault_in (fault_in),
  .cmd_out  (cmd_out)
);

// File: tb/test_bus_cmd_fault_slave.sv
`timescale 1ns/1ps
module test_bus_cmd_fault_slave;
  logic        clk = 1'b0;
  logic        rst, cs_n, rd_n, wr_n;
  logic [2:0]  addr;
  logic [3:0]  fault_in;
  logic        drv_en;
  logic [5:0]  drv_val;
  wire  [5:0]  bus;
  wire  [23:0] cmd_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [5:0] exp_cmd [4];

  localparam logic [5:0] RELEASED = 6'h3f;

  always #10 clk = ~clk;

  assign bus = drv_en ? drv_val : 6'bzzzzzz;
  for (genvar g = 0; g < 6; g++) begin : g_pu
    pullup (bus[g]);
  end

  bus_cmd_fault_slave i_bus_cmd_fault_slave (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .bus_data (bus),
    .fault_in (fault_in),
    .cmd_out  (cmd_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_cmds(input string req);
    for (int k = 0; k < 4; k++) check(req, cmd_out[k*6 +: 6], exp_cmd[k]);
  endtask

  // Write cycle; strobe held low for 'hold' cycles, check timing around the commit.
  task automatic bus_write(input logic cs, input logic [2:0] a, input logic [5:0] v,
                           input int hold, input string req);
    @(negedge clk);
    cs_n = cs; addr = a; drv_en = 1'b1; drv_val = v; wr_n = 1'b0;
    repeat (hold) begin
      @(negedge clk);
      check({req, " R9 strobe held low"}, cmd_out, {exp_cmd[3], exp_cmd[2], exp_cmd[1], exp_cmd[0]});
    end
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; drv_en = 1'b0;
    @(negedge clk);
    check_cmds({req, " R8 not yet committed"});
    if (!cs && !a[2]) exp_cmd[a[1:0]] = v;
    @(negedge clk);
    check_cmds(req);
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [5:0] exp, input string req);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    check(req, bus, exp);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_reset;
    rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0;
    fault_in = '0; drv_en = 1'b0; drv_val = '0;
    for (int k = 0; k < 4; k++) exp_cmd[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset commands", cmd_out, 24'h0);
    check("R7 released in reset", bus, RELEASED);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 commands after reset", cmd_out, 24'h0);
  endtask

  task automatic t_write_all;
    bus_write(1'b0, 3'd0, 6'h15, 3, "R2 write ch0");
    bus_write(1'b0, 3'd1, 6'h2a, 3, "R2 write ch1");
    bus_write(1'b0, 3'd2, 6'h3f, 3, "R2 write ch2");
    bus_write(1'b0, 3'd3, 6'h01, 3, "R2 write ch3");
  endtask

  task automatic t_hold;
    bus_write(1'b0, 3'd1, 6'h07, 3, "R3 rewrite ch1 others hold");
    bus_read(3'd6, 6'h00, "R3 read leaves commands");
    check_cmds("R3 after read");
  endtask

  task automatic t_ignored;
    bus_write(1'b0, 3'd5, 6'h33, 3, "R4 write to fault slot");
    bus_write(1'b1, 3'd2, 6'h00, 3, "R4 write without select");
  endtask

  task automatic t_long_strobe;
    bus_write(1'b0, 3'd3, 6'h2c, 9, "R9 long strobe commits once");
  endtask

  task automatic t_fault_read;
    fault_in = 4'b1010;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++)
      bus_read(3'(4 + k), {5'b0, fault_in[k]}, "R5 fault read");
    // latency of a fault change under a held read
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 3'd4;
    repeat (4) @(negedge clk);
    check("R5 held read before change", bus, 6'h00);
    fault_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 fault not yet visible", bus, 6'h00);
    @(negedge clk);
    check("R8 fault visible after 3 edges", bus, 6'h01);
    fault_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 fault cleared", bus, 6'h00);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic t_cmd_slot_read;
    fault_in = 4'b1111;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4; k++) bus_read(3'(k), 6'h00, "R6 command slot reads zero");
    bus_read(3'd7, 6'h01, "R5 fault slot with all faults");
  endtask

  task automatic t_release;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b1; addr = 3'd5;
    @(negedge clk);
    check("R7 released without read strobe", bus, RELEASED);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    check("R7 released without select", bus, RELEASED);
    cs_n = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R7 released during reset", bus, RELEASED);
    for (int k = 0; k < 4; k++) exp_cmd[k] = '0;
    check_cmds("R1 reset clears commands");
    cs_n = 1'b1; rd_n = 1'b1; rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_write_all();
    t_hold();
    t_ignored();
    t_long_strobe();
    t_fault_read();
    t_cmd_slot_read();
    t_release();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule